// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines, ranks the unmasked ones against the levels already in service, and raises a single interrupt line toward the processor. When the processor acknowledges with a falling edge on the active-low acknowledge input, the controller records the winning level as in service. It then returns an 8-bit vector made of a programmable base and the winning level number. The vector leaves on a valid/ready stream. `vec_valid_o` rises the cycle after the acknowledge edge. Vector data stays stable while `vec_ready_i` is low, and the word is consumed on the first clock edge where valid and ready are both high. A new acknowledge is not accepted while a vector is still waiting.

Software programs the block through a small write-only port with four selectable registers: request mask, vector base, mode and command. Priority is circular. A "lowest level" pointer sets the ranking: the level just after the pointer ranks highest, and the order wraps around. After reset the pointer is 7, which gives a fixed order with level 0 first. The pointer moves when software names a level directly, or automatically when rotation mode is on. An in-service bit is released by a command that names the level, by a command that releases the highest-ranked level in service, or by the acknowledge itself in auto-release mode.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the mask is clear, no level is in service, the lowest-priority pointer is 7 (level 0 ranks highest), rotation and auto-release are off, the base is 0, and both `int_o` and `vec_valid_o` are low.
- R2: With the pointer at 7, the lowest-numbered pending unmasked level wins. The vector is base bits [7:3] (written through select 1) above the 3-bit level number.
- R3: Writing select 0 sets the mask, where bit i blocks request line i. A masked request never raises `int_o`. Clearing the bit lets the request through.
- R4: A falling edge on `inta_n_i` while no vector is waiting puts the winner in service and raises `vec_valid_o` on the next cycle. `vec_data_o` stays stable while `vec_ready_i` is low. The word is removed on a valid-and-ready edge.
- R5: A pending request raises `int_o` only when it ranks above every level in service. A request of equal or lower rank waits.
- R6: A command write (select 3) with data bits [6:4] = 1 releases the highest-ranked in-service level.
- R7: A command with bits [6:4] = 2 releases the in-service level named in data bits [2:0].
- R8: With mode bit 1 (auto-release) set, an acknowledge does not mark the level in service, so a lower-ranked request can interrupt right after it.
- R9: With mode bit 0 (rotation) set, the level released by an R6 command becomes the lowest priority. In auto-release mode, the acknowledged level becomes the lowest priority.
- R10: A command with bits [6:4] = 3 makes the level in data bits [2:0] the lowest priority. The other levels follow in circular order.
- R11: An acknowledge edge with no request to forward returns base with low bits 7 and leaves the in-service state unchanged.
- R12: An acknowledge edge while a vector is still waiting is ignored and produces no extra vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Level-sensitive request lines |
| int_o | output | 1 | Interrupt request to the processor |
| inta_n_i | input | 1 | Active-low acknowledge from the processor |
| vec_valid_o | output | 1 | Vector stream valid |
| vec_ready_i | input | 1 | Vector stream ready |
| vec_data_o | output | 8 | Vector: base and level number |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 mask, 1 base, 2 mode, 3 command |
| wr_data_i | input | 8 | Register write data |

## Verification
Several patterns exercise the resolver. Simultaneous requests under the fixed order show whether ranking runs by level number. Nested requests, one above and one below an in-service level, show whether in-service state gates forwarding. Paired requests after each rotation event, whether automatic on release, automatic on acknowledge, or named by a command, show whether the pointer moved to the right level. A spurious acknowledge, a second acknowledge during back-pressure, and a masked request show the cases where the block must keep quiet or hold its output.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // register selects on the write port
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
  localparam logic [1:0] SEL_CMD  = 2'd3;

  // command opcodes carried in data bits [6:4]
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_EOI_TOP  = 3'd1,
    OP_EOI_LVL  = 3'd2,
    OP_SET_LOW  = 3'd3
  } cmd_op_e;
endpackage

// File: rtl/pic_rank_pick.sv
// Circular priority search: the level after `low_i` ranks 0 (highest).
// N must be a power of two so that level arithmetic wraps naturally.
module pic_rank_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] low_i,
  output logic          found_o,
  output logic [LW-1:0] idx_o,
  output logic [LW-1:0] rank_o
);
  logic [LW-1:0] lvl;

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    rank_o  = '0;
    lvl     = '0;
    for (int r = 0; r < N; r++) begin
      lvl = low_i + LW'(1) + LW'(r);
      if (!found_o && vec_i[lvl]) begin
        found_o = 1'b1;
        idx_o   = lvl;
        rank_o  = LW'(r);
      end
    end
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned LW = $clog2(N),
  localparam int unsigned BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [N-1:0]  mask_o,
  output logic [BW-1:0] base_o,
  output logic          rot_en_o,
  output logic          aeoi_o,
  output logic          eoi_top_o,
  output logic          eoi_lvl_o,
  output logic          set_low_o,
  output logic [LW-1:0] cmd_lvl_o
);
  logic [N-1:0]  mask_q;
  logic [BW-1:0] base_q;
  logic          rot_q, aeoi_q;
  cmd_op_e       op;
  logic          cmd_wr;

  assign op        = cmd_op_e'(wr_data_i[6:4]);
  assign cmd_wr    = wr_en_i && (wr_sel_i == SEL_CMD);
  assign eoi_top_o = cmd_wr && (op == OP_EOI_TOP);
  assign eoi_lvl_o = cmd_wr && (op == OP_EOI_LVL);
  assign set_low_o = cmd_wr && (op == OP_SET_LOW);
  assign cmd_lvl_o = wr_data_i[LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
      rot_q  <= 1'b0;
      aeoi_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_MASK: mask_q <= wr_data_i[N-1:0];
        SEL_BASE: base_q <= wr_data_i[DW-1:LW];
        SEL_MODE: begin
          rot_q  <= wr_data_i[0];
          aeoi_q <= wr_data_i[1];
        end
        default: ;
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign base_o   = base_q;
  assign rot_en_o = rot_q;
  assign aeoi_o   = aeoi_q;

  // R3: a mask write lands on the next edge
  p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == SEL_MASK) |=> (mask_o == $past(wr_data_i[N-1:0])));

  // R10/R6/R7: only one command kind decodes per write
  p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoi_top_o, eoi_lvl_o, set_low_o}));
endmodule

// File: rtl/pic_core.sv
// In-service state, priority pointer and the vector stream output.
module pic_core #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 8,
  localparam int unsigned LW = $clog2(N),
  localparam int unsigned BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_evt_i,
  input  logic          fwd_i,
  input  logic [LW-1:0] fwd_idx_i,
  input  logic          top_found_i,
  input  logic [LW-1:0] top_idx_i,
  input  logic          rot_en_i,
  input  logic          aeoi_i,
  input  logic [BW-1:0] base_i,
  input  logic          eoi_top_i,
  input  logic          eoi_lvl_i,
  input  logic          set_low_i,
  input  logic [LW-1:0] cmd_lvl_i,
  input  logic          vec_ready_i,
  output logic [N-1:0]  isr_o,
  output logic [LW-1:0] low_o,
  output logic          vec_valid_o,
  output logic [DW-1:0] vec_data_o
);
  logic [N-1:0]  isr_q, isr_d;
  logic [LW-1:0] low_q, low_d;
  logic          vv_q;
  logic [DW-1:0] vd_q;
  logic          take;

  assign take = ack_evt_i && !vv_q;

  always_comb begin
    isr_d = isr_q;
    low_d = low_q;
    if (take && fwd_i && !aeoi_i) isr_d[fwd_idx_i] = 1'b1;
    if (take && fwd_i && aeoi_i && rot_en_i) low_d = fwd_idx_i;
    if (eoi_top_i && top_found_i) begin
      isr_d[top_idx_i] = 1'b0;
      if (rot_en_i) low_d = top_idx_i;
    end
    if (eoi_lvl_i) isr_d[cmd_lvl_i] = 1'b0;
    if (set_low_i) low_d = cmd_lvl_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      low_q <= LW'(N - 1);
      vv_q  <= 1'b0;
      vd_q  <= '0;
    end else begin
      isr_q <= isr_d;
      low_q <= low_d;
      if (take) begin
        vv_q <= 1'b1;
        vd_q <= {base_i, (fwd_i ? fwd_idx_i : LW'(N - 1))};
      end else if (vv_q && vec_ready_i) begin
        vv_q <= 1'b0;
      end
    end
  end

  assign isr_o       = isr_q;
  assign low_o       = low_q;
  assign vec_valid_o = vv_q;
  assign vec_data_o  = vd_q;

  p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vv_q && !vec_ready_i) |=> (vv_q && $stable(vd_q)));

  p_isr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fwd_i && !aeoi_i && !eoi_lvl_i) |=> isr_q[$past(fwd_idx_i)]);

  p_aeoi_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && aeoi_i && !eoi_top_i && !eoi_lvl_i) |=> (isr_q == $past(isr_q)));

  p_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fwd_i) |=> (vd_q[LW-1:0] == LW'(N - 1)));

  p_busy_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_evt_i && vv_q && !vec_ready_i) |=> (vv_q && $stable(vd_q)));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int unsigned N_IRQ = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW = $clog2(N_IRQ),
  localparam int unsigned BW = DW - LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  output logic             int_o,
  input  logic             inta_n_i,
  output logic             vec_valid_o,
  input  logic             vec_ready_i,
  output logic [DW-1:0]    vec_data_o,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i
);
  logic [N_IRQ-1:0] irr_q, mask, isr, req;
  logic             inta_prev_q, ack_evt;
  logic [BW-1:0]    base;
  logic             rot_en, aeoi, eoi_top, eoi_lvl, set_low;
  logic [LW-1:0]    cmd_lvl, low;
  logic             req_found, top_found, fwd;
  logic [LW-1:0]    req_idx, req_rank, top_idx, top_rank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q       <= '0;
      inta_prev_q <= 1'b1;
    end else begin
      irr_q       <= irq_i;
      inta_prev_q <= inta_n_i;
    end
  end

  assign ack_evt = inta_prev_q && !inta_n_i;
  assign req     = irr_q & ~mask;

  pic_regs #(.N(N_IRQ), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .mask_o(mask), .base_o(base), .rot_en_o(rot_en), .aeoi_o(aeoi),
    .eoi_top_o(eoi_top), .eoi_lvl_o(eoi_lvl), .set_low_o(set_low),
    .cmd_lvl_o(cmd_lvl)
  );

  pic_rank_pick #(.N(N_IRQ)) u_req_pick (
    .vec_i(req), .low_i(low),
    .found_o(req_found), .idx_o(req_idx), .rank_o(req_rank)
  );

  pic_rank_pick #(.N(N_IRQ)) u_isr_pick (
    .vec_i(isr), .low_i(low),
    .found_o(top_found), .idx_o(top_idx), .rank_o(top_rank)
  );

  assign fwd   = req_found && (!top_found || (req_rank < top_rank));
  assign int_o = fwd;

  pic_core #(.N(N_IRQ), .DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .ack_evt_i(ack_evt), .fwd_i(fwd), .fwd_idx_i(req_idx),
    .top_found_i(top_found), .top_idx_i(top_idx),
    .rot_en_i(rot_en), .aeoi_i(aeoi), .base_i(base),
    .eoi_top_i(eoi_top), .eoi_lvl_i(eoi_lvl),
    .set_low_i(set_low), .cmd_lvl_i(cmd_lvl),
    .vec_ready_i(vec_ready_i),
    .isr_o(isr), .low_o(low),
    .vec_valid_o(vec_valid_o), .vec_data_o(vec_data_o)
  );

  p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (irr_q[req_idx] && !mask[req_idx]));

  p_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> !isr[req_idx]);
endmodule

// File: tb/pic_ctrl_bench.sv
module pic_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       int_o;
  logic       inta_n = 1'b1;
  logic       vvalid;
  logic       vready = 1'b1;
  logic [7:0] vdata;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;

  int unsigned checks = 0;
  int unsigned errors = 0;
  logic [7:0]  exp_q[$];
  string       exp_tag[$];
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pic_ctrl u_pic_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .int_o(int_o),
    .inta_n_i(inta_n), .vec_valid_o(vvalid), .vec_ready_i(vready),
    .vec_data_o(vdata), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected vector per accepted stream word
  always @(negedge clk) begin
    if (rst_n && vvalid && vready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected vector", vdata, 0);
      end else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(vdata == e, t, vdata, e);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    irq = v;
    step();
  endtask

  task automatic ack(input logic [7:0] e, input string tag, input bit expect_vec);
    if (expect_vec) begin
      exp_q.push_back(e);
      exp_tag.push_back(tag);
    end
    inta_n = 1'b0;
    step();
    inta_n = 1'b1;
    step();
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 vready = v;
    step();
  endtask

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check(int_o == 1'b0, "R1 int after reset", int_o, 0);
    check(vvalid == 1'b0, "R1 valid after reset", vvalid, 0);

    wr(2'd1, 8'h40);               // base 0x40
    // R2 fixed order: 3 beats 5
    set_irq(8'b0010_1000);
    check(int_o == 1'b1, "R2 int raised", int_o, 1);
    ack(8'h43, "R2 vector level 3", 1);
    check(int_o == 1'b0, "R5 lower level waits", int_o, 0);
    set_irq(8'b0010_0000);
    set_irq(8'b0010_0010);
    check(int_o == 1'b1, "R5 higher level nests", int_o, 1);
    ack(8'h41, "R5 nested vector", 1);
    set_irq(8'b0010_0000);
    wr(2'd3, 8'h10);               // R6 release top (level 1)
    check(int_o == 1'b0, "R6 level 3 still in service", int_o, 0);
    wr(2'd3, 8'h10);               // R6 release level 3
    check(int_o == 1'b1, "R6 level 5 forwarded", int_o, 1);
    ack(8'h45, "R6 vector level 5", 1);
    set_irq(8'b0100_0000);
    check(int_o == 1'b0, "R5 level 6 waits for 5", int_o, 0);
    wr(2'd3, 8'h25);               // R7 release level 5
    check(int_o == 1'b1, "R7 named release", int_o, 1);
    ack(8'h46, "R7 vector level 6", 1);
    set_irq(8'h00);
    wr(2'd3, 8'h26);

    // R3 mask
    wr(2'd0, 8'b0000_0100);
    set_irq(8'b0000_0100);
    step(); step();
    check(int_o == 1'b0, "R3 masked request", int_o, 0);
    wr(2'd0, 8'h00);
    check(int_o == 1'b1, "R3 unmasked request", int_o, 1);
    ack(8'h42, "R3 vector level 2", 1);
    set_irq(8'h00);
    wr(2'd3, 8'h10);

    // R11 spurious
    ack(8'h47, "R11 spurious vector", 1);
    check(int_o == 1'b0, "R11 no int after spurious", int_o, 0);
    set_irq(8'b1000_0000);
    check(int_o == 1'b1, "R11 in-service unchanged", int_o, 1);
    ack(8'h47, "R11 real level 7", 1);
    set_irq(8'h00);
    wr(2'd3, 8'h10);

    // R4 back-pressure and R12 busy acknowledge
    set_ready(1'b0);
    set_irq(8'h01);
    ack(8'h40, "R4 held vector", 1);
    check(vvalid == 1'b1, "R4 valid held", vvalid, 1);
    check(vdata == 8'h40, "R4 data held", vdata, 8'h40);
    ack(8'h00, "", 0);
    check(vvalid == 1'b1, "R12 still valid", vvalid, 1);
    check(vdata == 8'h40, "R12 data unchanged", vdata, 8'h40);
    set_ready(1'b1);
    step();
    check(vvalid == 1'b0, "R12 no extra vector", vvalid, 0);
    set_irq(8'h00);
    wr(2'd3, 8'h10);

    // R8 auto-release
    wr(2'd2, 8'h02);
    set_irq(8'b0001_0000);
    ack(8'h44, "R8 vector level 4", 1);
    set_irq(8'b0100_0000);
    check(int_o == 1'b1, "R8 lower level not blocked", int_o, 1);
    ack(8'h46, "R8 vector level 6", 1);
    set_irq(8'h00);

    // R9 rotation on acknowledge (auto-release)
    wr(2'd2, 8'h03);
    set_irq(8'b0000_0100);
    ack(8'h42, "R9 vector level 2", 1);
    set_irq(8'b0000_1010);
    ack(8'h43, "R9 level 3 ranks above 1", 1);
    set_irq(8'b0000_0010);
    ack(8'h41, "R9 vector level 1", 1);
    set_irq(8'h00);

    // R9 rotation on release
    wr(2'd3, 8'h37);               // R10 pointer back to 7
    wr(2'd2, 8'h01);
    set_irq(8'b0010_0000);
    ack(8'h45, "R9 vector level 5", 1);
    set_irq(8'h00);
    wr(2'd3, 8'h10);               // lowest becomes 5
    set_irq(8'b0101_0000);
    ack(8'h46, "R9 level 6 ranks above 4", 1);
    set_irq(8'b0001_0000);
    wr(2'd3, 8'h10);
    check(int_o == 1'b1, "R9 level 4 after release", int_o, 1);
    ack(8'h44, "R9 vector level 4", 1);
    set_irq(8'h00);
    wr(2'd3, 8'h10);

    // R10 named pointer
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h34);               // lowest = 4
    set_irq(8'b0101_0001);
    ack(8'h46, "R10 level 6 first", 1);
    set_irq(8'b0001_0001);
    wr(2'd3, 8'h10);
    ack(8'h40, "R10 level 0 second", 1);
    set_irq(8'b0001_0000);
    wr(2'd3, 8'h10);
    ack(8'h44, "R10 level 4 last", 1);
    set_irq(8'h00);
    wr(2'd3, 8'h10);
    step(); step();

    check(exp_q.size() == 0, "R4 all vectors delivered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule